// File: doc/BRIEF.md
# Runt-Filtering Receive FIFO

This block sits between a receive MAC and a host transfer engine. Each cycle the MAC may push one byte, flag the byte that ends a frame, or signal that the frame in progress was cut short by a collision. The FIFO stores up to 128 bytes. It shows none of a frame to the host until that frame has reached the minimum legal length of 64 bytes. A frame that ends or collides before that point leaves no trace in the buffer: the write pointer returns to where the frame began. The matching 8-bit discard counter then advances.

On the host side a transfer request tells the host when to fetch bytes through a byte-wide read port. The first request for a frame never comes before the 64-byte point. After that, a 2-bit watermark sets how many committed but unread bytes must build up before the request is raised again while the frame keeps arriving. Once raised, the request holds until the host has read every committed byte. If the buffer fills, the block raises an overflow flag and drops the remainder of the frame. A frame whose first byte finds the buffer full is counted as missed.

Top module: `rx_runt_fifo`

## Requirements
- R1: After reset the transfer request is low, the overflow flag is low and the runt, collision and missed counters all read zero.
- R2: Bytes of accepted frames are read back on `rd_data` in the order they were written, frames in arrival order.
- R3: No byte of a frame becomes readable and the request stays low until the 64th byte of the frame is written; the request is high in the cycle after that byte is accepted.
- R4: A frame whose end-of-frame byte arrives before it reaches 64 bytes leaves no readable byte, rewinds the write pointer to the frame's start, and increments `runt_count` by one.
- R5: An abort while a frame holds fewer than 64 bytes erases the frame and increments `coll_count` by one; an abort with no frame in progress has no effect.
- R6: An abort after a frame has passed 64 bytes ends the frame and keeps every byte already accepted; no counter changes.
- R7: While a frame that has passed 64 bytes keeps arriving and the request is low, the request rises when the committed unread byte count reaches the watermark level: `wm_sel` 0 selects 16, 1 selects 32, 2 and 3 select 64.
- R8: Once raised, the request stays high until no committed byte remains unread.
- R9: When a frame has ended, any committed unread bytes raise the request, even when they are fewer than the watermark level.
- R10: A byte that arrives when 128 bytes are stored sets `overflow`; the rest of that frame is dropped (all of it if it had not passed 64 bytes); the flag clears when the next frame's first byte arrives.
- R11: A frame whose first byte arrives while the buffer is full increments `miss_count` by one, sets `overflow`, and is dropped entirely.
- R12: A read strobe while no committed byte is unread is ignored and does not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wm_sel | input | 2 | Watermark select: 0 is 16 bytes, 1 is 32 bytes, 2 and 3 are 64 bytes |
| wr_valid | input | 1 | A received byte is present on `wr_data` |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | With `wr_valid`, marks the final byte of the frame |
| wr_abort | input | 1 | Frame in progress ended by collision or abort; takes priority over `wr_valid` |
| rd_en | input | 1 | Host pops one byte |
| rd_data | output | 8 | Byte at the read position |
| rd_req | output | 1 | Transfer request to the host |
| overflow | output | 1 | Buffer overflow seen on the current or last frame |
| runt_count | output | 8 | Frames discarded for ending short |
| coll_count | output | 8 | Frames discarded for a collision before 64 bytes |
| miss_count | output | 8 | Frames missed because the buffer was full at their start |

## Verification
The bench runs through every runt length from 1 to 63 bytes and every abort point in the same range. These sweeps separate a correct rewind from one that is off by a byte, and they show whether the two discard counters are kept apart. For each of the four watermark codes, a frame is streamed one byte at a time past the 64-byte point. The request must stay low at exactly level minus one and rise at the level, which tells the codes apart. A short frame tail then checks that an ended frame raises the request below the level. Two fill patterns cover overflow: one fills the buffer completely before a new frame starts, which exercises the missed count, and one overflows in the middle of a frame, which exercises the partial rewind. A stray read during an uncommitted frame checks that the read position does not move.

// File: rtl/rxrf_pkg.sv
// Package: shared types and helpers for the runt-filtering receive FIFO.
// Assumes: nothing beyond standard SystemVerilog.
package rxrf_pkg;

    // Write-side frame state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // between frames
        ST_FILL = 2'd1,   // frame below the minimum length, uncommitted
        ST_PASS = 2'd2,   // frame past the minimum length, bytes committed as written
        ST_DROP = 2'd3    // overflow seen, discarding until frame end
    } rxrf_state_e;

    // Watermark byte level for a 2-bit select; code 3 behaves like code 2.
    function automatic int unsigned wm_bytes(input logic [1:0] sel, input int unsigned min_len);
        case (sel)
            2'd0:    return min_len / 4;
            2'd1:    return min_len / 2;
            default: return min_len;
        endcase
    endfunction

endpackage

// File: rtl/rxrf_store.sv
// Module: rxrf_store
// Byte storage for the FIFO: one synchronous write port, one asynchronous
// read port. Assumes DEPTH is a power of two; the array has no reset
// because the pointers alone decide which entries are valid.
module rxrf_store #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    // Store one incoming byte.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Present the byte at the read position.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxrf_frame_ctrl.sv
// Module: rxrf_frame_ctrl
// Write-side frame tracker. Keeps the speculative write pointer, the frame
// start pointer and the commit boundary. Commits a frame's bytes once it
// reaches MIN_LEN, rewinds short or collided frames, handles overflow and
// counts discards. Assumes MIN_LEN >= 2 and MIN_LEN <= DEPTH.
module rxrf_frame_ctrl
    import rxrf_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int MIN_LEN = 64,
    parameter int CW      = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1,
    localparam int LW     = $clog2(MIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_last,
    input  logic          wr_abort,
    input  logic [PW-1:0] rd_ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [PW-1:0] cmt_ptr,
    output logic          streaming,
    output logic          ovfl,
    output logic [CW-1:0] runt_cnt,
    output logic [CW-1:0] coll_cnt,
    output logic [CW-1:0] miss_cnt
);

    localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
    localparam logic [LW-1:0] LAST_UNC = LW'(MIN_LEN - 1);

    rxrf_state_e   state_q;
    logic [PW-1:0] wr_ptr_q;
    logic [PW-1:0] start_q;
    logic [PW-1:0] cmt_q;
    logic [LW-1:0] flen_q;
    logic          ovfl_q;
    logic [CW-1:0] runt_q, coll_q, miss_q;
    logic [PW-1:0] fill;
    logic          full;
    logic          byte_in;

    // Occupancy including uncommitted bytes.
    assign fill    = wr_ptr_q - rd_ptr;
    assign full    = (fill == FULL_LVL);
    assign byte_in = wr_valid && !wr_abort;

    // Memory write strobe: any byte that has room while a frame is being stored.
    assign mem_we    = byte_in && !full && (state_q != ST_DROP);
    assign mem_waddr = wr_ptr_q[AW-1:0];

    // Frame state, pointers, flag and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wr_ptr_q <= '0;
            start_q  <= '0;
            cmt_q    <= '0;
            flen_q   <= '0;
            ovfl_q   <= 1'b0;
            runt_q   <= '0;
            coll_q   <= '0;
            miss_q   <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                start_q <= wr_ptr_q;
            end
            if (wr_abort) begin
                if (state_q == ST_FILL) begin
                    wr_ptr_q <= start_q;
                    coll_q   <= coll_q + CW'(1);
                end
                state_q <= ST_IDLE;
            end else if (wr_valid) begin
                case (state_q)
                    ST_IDLE: begin
                        ovfl_q <= full;
                        if (full) begin
                            miss_q <= miss_q + CW'(1);
                            if (!wr_last) state_q <= ST_DROP;
                        end else if (wr_last) begin
                            runt_q <= runt_q + CW'(1);
                        end else begin
                            wr_ptr_q <= wr_ptr_q + PW'(1);
                            flen_q   <= LW'(1);
                            state_q  <= ST_FILL;
                        end
                    end
                    ST_FILL: begin
                        if (full) begin
                            ovfl_q   <= 1'b1;
                            wr_ptr_q <= start_q;
                            state_q  <= wr_last ? ST_IDLE : ST_DROP;
                        end else if (flen_q == LAST_UNC) begin
                            wr_ptr_q <= wr_ptr_q + PW'(1);
                            cmt_q    <= wr_ptr_q + PW'(1);
                            state_q  <= wr_last ? ST_IDLE : ST_PASS;
                        end else if (wr_last) begin
                            wr_ptr_q <= start_q;
                            runt_q   <= runt_q + CW'(1);
                            state_q  <= ST_IDLE;
                        end else begin
                            wr_ptr_q <= wr_ptr_q + PW'(1);
                            flen_q   <= flen_q + LW'(1);
                        end
                    end
                    ST_PASS: begin
                        if (full) begin
                            ovfl_q  <= 1'b1;
                            state_q <= wr_last ? ST_IDLE : ST_DROP;
                        end else begin
                            wr_ptr_q <= wr_ptr_q + PW'(1);
                            cmt_q    <= wr_ptr_q + PW'(1);
                            if (wr_last) state_q <= ST_IDLE;
                        end
                    end
                    default: begin
                        if (wr_last) state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign cmt_ptr   = cmt_q;
    assign streaming = (state_q == ST_PASS);
    assign ovfl      = ovfl_q;
    assign runt_cnt  = runt_q;
    assign coll_cnt  = coll_q;
    assign miss_cnt  = miss_q;

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL_LVL);

    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> ((wr_ptr_q - start_q) < PW'(MIN_LEN)));

    // R4
    runt_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && byte_in && wr_last && !full && flen_q != LAST_UNC)
        |=> (wr_ptr_q == $past(start_q)));

    // R4
    runt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (runt_q != $past(runt_q)) |-> (runt_q == $past(runt_q) + CW'(1)));

    // R5
    coll_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_q != $past(coll_q)) |-> (coll_q == $past(coll_q) + CW'(1)));

    // R2
    commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_q - rd_ptr) <= fill);

endmodule

// File: rtl/rxrf_read_side.sv
// Module: rxrf_read_side
// Host-side read pointer and transfer-request generation. The request
// rises on the watermark while a frame streams, on any committed data once
// no frame streams, and then holds until committed data runs out.
// Assumes cmt_ptr never moves backward.
module rxrf_read_side
    import rxrf_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int MIN_LEN = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wm_sel,
    input  logic          rd_en,
    input  logic [PW-1:0] cmt_ptr,
    input  logic          streaming,
    output logic [PW-1:0] rd_ptr,
    output logic          rd_req
);

    logic [PW-1:0] rd_ptr_q;
    logic [PW-1:0] unread;
    logic [PW-1:0] wm_level;
    logic          hold_q;
    logic          have;

    // Committed bytes not yet read and the selected watermark.
    assign unread   = cmt_ptr - rd_ptr_q;
    assign have     = (unread != '0);
    assign wm_level = PW'(wm_bytes(wm_sel, MIN_LEN));

    // Request: hold, watermark reached, or no frame still streaming.
    assign rd_req = have && (hold_q || (unread >= wm_level) || !streaming);

    // Advance the read position and remember the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            hold_q   <= 1'b0;
        end else begin
            if (rd_en && have) rd_ptr_q <= rd_ptr_q + PW'(1);
            hold_q <= rd_req;
        end
    end

    assign rd_ptr = rd_ptr_q;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_en) |=> rd_req);

    // R12
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !have) |=> $stable(rd_ptr_q));

endmodule

// File: rtl/rx_runt_fifo.sv
// Module: rx_runt_fifo (top)
// Receive FIFO that hides frames from the host until they pass the minimum
// length, erasing runts and early-collision fragments. Assumes DEPTH is a
// power of two and MIN_LEN <= DEPTH.
module rx_runt_fifo #(
    parameter int DEPTH   = 128,
    parameter int MIN_LEN = 64,
    parameter int DW      = 8,
    parameter int CW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wm_sel,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    input  logic          wr_abort,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic          overflow,
    output logic [CW-1:0] runt_count,
    output logic [CW-1:0] coll_count,
    output logic [CW-1:0] miss_count
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [PW-1:0] cmt_ptr;
    logic [PW-1:0] rd_ptr;
    logic          streaming;

    rxrf_frame_ctrl #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_last   (wr_last),
        .wr_abort  (wr_abort),
        .rd_ptr    (rd_ptr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .cmt_ptr   (cmt_ptr),
        .streaming (streaming),
        .ovfl      (overflow),
        .runt_cnt  (runt_count),
        .coll_cnt  (coll_count),
        .miss_cnt  (miss_count)
    );

    rxrf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_data)
    );

    rxrf_read_side #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wm_sel    (wm_sel),
        .rd_en     (rd_en),
        .cmt_ptr   (cmt_ptr),
        .streaming (streaming),
        .rd_ptr    (rd_ptr),
        .rd_req    (rd_req)
    );

endmodule

// File: tb/rx_runt_fifo_bench.sv
module rx_runt_fifo_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] wm_sel;
    logic       wr_valid, wr_last, wr_abort, rd_en;
    logic [7:0] wr_data, rd_data;
    logic       rd_req, overflow;
    logic [7:0] runt_count, coll_count, miss_count;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_runt_fifo u_rx_runt_fifo (
        .clk(clk), .rst_n(rst_n), .wm_sel(wm_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_abort(wr_abort),
        .rd_en(rd_en), .rd_data(rd_data), .rd_req(rd_req), .overflow(overflow),
        .runt_count(runt_count), .coll_count(coll_count), .miss_count(miss_count)
    );

    function automatic logic [7:0] pat(input int f, input int i);
        return 8'((f * 37 + i) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic send(input int f, input int first, input int n, input bit end_frame);
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_data  = pat(f, first + i);
            wr_last  = end_frame && (i == n - 1);
            @(posedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
            wr_last  = 1'b0;
        end
    endtask

    task automatic abort_pulse();
        wr_abort = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_abort = 1'b0;
    endtask

    task automatic drain(input int f, input int first, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, rd_data, pat(f, first + i));
            chk("R8 hold", rd_req, 1);
            rd_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wm_sel = 2'd0;
        wr_valid = 1'b0; wr_last = 1'b0; wr_abort = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 req", rd_req, 0);
        chk("R1 ovfl", overflow, 0);
        chk("R1 runt", runt_count, 0);
        chk("R1 coll", coll_count, 0);
        chk("R1 miss", miss_count, 0);

        // R5: abort with no frame in progress has no effect
        abort_pulse();
        chk("R5 idle abort", coll_count, 0);

        // R4: every runt length
        for (int len = 1; len < 64; len++) begin
            send(1, 0, len, 1'b1);
            chk("R4 runt count", runt_count, len);
            chk("R4 hidden", rd_req, 0);
        end

        // R5: every abort point below the minimum
        for (int len = 1; len < 64; len++) begin
            send(2, 0, len, 1'b0);
            abort_pulse();
            chk("R5 coll count", coll_count, len);
            chk("R5 hidden", rd_req, 0);
        end
        chk("R4 runt unchanged", runt_count, 63);

        // R3: gate at the 64th byte, then R2 order
        send(200, 0, 63, 1'b0);
        chk("R3 before 64", rd_req, 0);
        send(200, 63, 1, 1'b0);
        chk("R3 at 64", rd_req, 1);
        send(200, 64, 6, 1'b1);
        drain(200, 0, 70, "R2 data");
        chk("R2 empty", rd_req, 0);

        // R7 / R9: watermark codes
        for (int w = 0; w < 4; w++) begin
            int lvl;
            int f;
            lvl = (w == 0) ? 16 : (w == 1) ? 32 : 64;
            f = 10 + w;
            wm_sel = 2'(w);
            send(f, 0, 64, 1'b0);
            drain(f, 0, 64, "R2 data");
            chk("R7 drained", rd_req, 0);
            for (int k = 1; k <= lvl; k++) begin
                send(f, 63 + k, 1, 1'b0);
                chk("R7 watermark", rd_req, (k >= lvl) ? 1 : 0);
            end
            drain(f, 64, lvl, "R7 data");
            send(f, 64 + lvl, 2, 1'b0);
            chk("R9 below level", rd_req, 0);
            send(f, 66 + lvl, 1, 1'b1);
            chk("R9 frame end", rd_req, 1);
            drain(f, 64 + lvl, 3, "R9 data");
            chk("R9 empty", rd_req, 0);
        end
        wm_sel = 2'd0;

        // R12: stray read while nothing committed
        send(50, 0, 10, 1'b0);
        chk("R12 hidden", rd_req, 0);
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        send(50, 10, 54, 1'b1);
        drain(50, 0, 64, "R12 data");

        // R6: abort after the minimum keeps the bytes
        send(60, 0, 66, 1'b0);
        abort_pulse();
        chk("R6 coll", coll_count, 63);
        chk("R6 runt", runt_count, 63);
        drain(60, 0, 66, "R6 data");
        chk("R6 empty", rd_req, 0);

        // R11: frame starting on a full buffer
        send(70, 0, 128, 1'b1);
        chk("R11 ovfl before", overflow, 0);
        send(71, 0, 1, 1'b0);
        chk("R11 miss", miss_count, 1);
        chk("R11 ovfl", overflow, 1);
        send(71, 1, 3, 1'b1);
        drain(70, 0, 128, "R11 data");
        chk("R11 dropped", rd_req, 0);

        // R10: overflow in mid frame
        send(72, 0, 100, 1'b1);
        send(73, 0, 28, 1'b0);
        chk("R10 not yet", overflow, 0);
        send(73, 28, 1, 1'b0);
        chk("R10 set", overflow, 1);
        send(73, 29, 11, 1'b1);
        chk("R10 miss", miss_count, 1);
        chk("R10 runt", runt_count, 63);
        drain(72, 0, 100, "R10 data");
        chk("R10 dropped", rd_req, 0);
        send(74, 0, 1, 1'b0);
        chk("R10 clear", overflow, 0);
        send(74, 1, 63, 1'b1);
        drain(74, 0, 64, "R10 next");
        chk("R10 empty", rd_req, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule